// File: doc/BRIEF.md
# Vector Interleave and De-interleave Permuter

This block rearranges the elements of short vectors held as flat register arrays. One operation takes two source arrays and writes a destination array in which elements are interleaved, de-interleaved or paired. Five operations are offered:

- zip: interleaves two sources into a destination twice as long.
- unzip-even and unzip-odd: take the even-indexed or odd-indexed elements of a double-length source.
- pair-even and pair-odd: take the even-indexed or odd-indexed elements of both sources and interleave them.

Every operation can be limited by a per-destination-element mask. The caller also supplies the prior destination contents. Elements that are masked off, and elements past the active length, come back with their prior value.

An operation is offered with a valid/ready handshake. The unit captures the operands in the accepting cycle and computes the result in the following cycle. It then presents the destination array and its active length with a one-cycle done pulse, and holds them until the next result. The element width and the maximum vector length are parameters. The runtime vector length is clamped to that maximum.

Top module: `vzp_permuter`

## Requirements
- R1: While reset is asserted and after it is released, in_ready_o is 1, done_o is 0, and vd_o and len_o are all zeros.
- R2: Opcode 0 (zip) sets len_o to 2*vl. Destination element 2i equals vs2 element i and element 2i+1 equals vs1 element i, for i < vl. Element k of any array occupies bits [k*EW +: EW].
- R3: Opcode 1 (unzip-even) writes dest[i] = vs2[2i] and opcode 2 (unzip-odd) writes dest[i] = vs2[2i+1], for i < vl. vs2 holds 2*MAX_VL elements and len_o is vl.
- R4: Opcode 3 (pair-even) writes dest[2k] = vs2[2k] and dest[2k+1] = vs1[2k] for destination indices below vl. len_o is vl.
- R5: Opcode 4 (pair-odd) writes dest[2k] = vs2[2k+1] and dest[2k+1] = vs1[2k+1] for destination indices below vl. A vs2 read at an index at or beyond MAX_VL yields zero, even though vs2 holds data there.
- R6: With mask_en_i at 1, a destination element d whose mask bit mask_i[d] is 0 returns the corresponding vd_old_i element. With mask_en_i at 0, all elements below the active length are written.
- R7: Destination elements at indices at or beyond len_o return the corresponding vd_old_i element.
- R8: A vl_i above MAX_VL behaves as vl = MAX_VL, so len_o never exceeds 2*MAX_VL.
- R9: Opcodes 5 to 7 are reserved. They produce len_o = 0 and a destination equal to vd_old_i.
- R10: An operation is accepted on a clock edge where in_valid_i and in_ready_o are both 1. in_ready_o is 0 for the next cycle. done_o is 1 for exactly the cycle after that, and the result appears in that same cycle.
- R11: Input offered while in_ready_o is 0 is ignored. vd_o and len_o change only in a cycle where done_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Unit can accept an operation |
| op_i | input | 3 | Opcode (0 zip, 1 unzip-even, 2 unzip-odd, 3 pair-even, 4 pair-odd) |
| vl_i | input | $clog2(2*MAX_VL+1) | Requested vector length |
| mask_en_i | input | 1 | Apply the mask |
| mask_i | input | 2*MAX_VL | One enable bit per destination element |
| vs2_i | input | 2*MAX_VL*EW | First source, double length |
| vs1_i | input | MAX_VL*EW | Second source |
| vd_old_i | input | 2*MAX_VL*EW | Prior destination contents |
| done_o | output | 1 | Result valid pulse |
| vd_o | output | 2*MAX_VL*EW | Destination array |
| len_o | output | $clog2(2*MAX_VL+1) | Active destination length |

## Verification
Zip is driven at full length and at a short length. These two runs show the doubled length apart from the tail that stays untouched. Both unzip variants read the same double-length source, so a swapped even/odd selection shows at once. Pair-odd is run with an odd vl equal to an odd MAX_VL, which places a non-zero value in vs2 just past the limit and exposes a missing zero-force. Sparse masks, an over-long vl, a reserved opcode and data changed while the unit is busy each separate one more rule from the main path.

// File: rtl/vzp_pkg.sv
package vzp_pkg;
   typedef enum logic [2:0] {
      OP_ZIP     = 3'd0,
      OP_UNZIP_E = 3'd1,
      OP_UNZIP_O = 3'd2,
      OP_PAIR_E  = 3'd3,
      OP_PAIR_O  = 3'd4
   } vzp_op_e;
endpackage

// File: rtl/vzp_src_sel.sv
module vzp_src_sel
   import vzp_pkg::*;
#(
   parameter int EW     = 8,
   parameter int MAX_VL = 8,
   localparam int DLEN  = 2 * MAX_VL
) (
   input  logic [2:0]         op_i,
   input  logic [DLEN*EW-1:0]   vs2_i,
   input  logic [MAX_VL*EW-1:0] vs1_i,
   output logic [DLEN*EW-1:0]   cand_o
);
   for (genvar d = 0; d < DLEN; d++) begin : g_el
      logic [EW-1:0] z_e, ue_e, uo_e, pe_e, po_e, sel_e;

      if ((d % 2) == 0) begin : g_zev
         assign z_e = vs2_i[(d/2)*EW +: EW];
      end else begin : g_zod
         assign z_e = vs1_i[(d/2)*EW +: EW];
      end

      if (d < MAX_VL) begin : g_lo
         assign ue_e = vs2_i[(2*d)*EW +: EW];
         assign uo_e = vs2_i[(2*d+1)*EW +: EW];
         if ((d % 2) == 0) begin : g_pev
            assign pe_e = vs2_i[d*EW +: EW];
            if (d + 1 < MAX_VL) begin : g_in
               assign po_e = vs2_i[(d+1)*EW +: EW];
            end else begin : g_zero
               assign po_e = '0;
            end
         end else begin : g_pod
            assign pe_e = vs1_i[(d-1)*EW +: EW];
            assign po_e = vs1_i[d*EW +: EW];
         end
      end else begin : g_hi
         assign ue_e = '0;
         assign uo_e = '0;
         assign pe_e = '0;
         assign po_e = '0;
      end

      always_comb begin
         case (op_i)
            OP_ZIP:     sel_e = z_e;
            OP_UNZIP_E: sel_e = ue_e;
            OP_UNZIP_O: sel_e = uo_e;
            OP_PAIR_E:  sel_e = pe_e;
            OP_PAIR_O:  sel_e = po_e;
            default:    sel_e = '0;
         endcase
      end

      assign cand_o[d*EW +: EW] = sel_e;
   end
endmodule

// File: rtl/vzp_merge.sv
module vzp_merge #(
   parameter int EW   = 8,
   parameter int DLEN = 16,
   parameter int LW   = 5
) (
   input  logic [DLEN*EW-1:0] cand_i,
   input  logic [DLEN*EW-1:0] old_i,
   input  logic [DLEN-1:0]    mask_i,
   input  logic               mask_en_i,
   input  logic [LW-1:0]      len_i,
   output logic [DLEN*EW-1:0] vd_o
);
   for (genvar d = 0; d < DLEN; d++) begin : g_el
      localparam logic [LW-1:0] IDX = LW'(d);
      logic act;
      assign act = (IDX < len_i) && (!mask_en_i || mask_i[d]);
      assign vd_o[d*EW +: EW] = act ? cand_i[d*EW +: EW] : old_i[d*EW +: EW];
   end
endmodule

// File: rtl/vzp_permuter.sv
module vzp_permuter
   import vzp_pkg::*;
#(
   parameter int EW     = 8,
   parameter int MAX_VL = 8,
   localparam int DLEN  = 2 * MAX_VL,
   localparam int LW    = $clog2(DLEN + 1)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 in_valid_i,
   output logic                 in_ready_o,
   input  logic [2:0]           op_i,
   input  logic [LW-1:0]        vl_i,
   input  logic                 mask_en_i,
   input  logic [DLEN-1:0]      mask_i,
   input  logic [DLEN*EW-1:0]   vs2_i,
   input  logic [MAX_VL*EW-1:0] vs1_i,
   input  logic [DLEN*EW-1:0]   vd_old_i,
   output logic                 done_o,
   output logic [DLEN*EW-1:0]   vd_o,
   output logic [LW-1:0]        len_o
);
   if (EW < 1) begin : g_bad_ew
      $error("vzp_permuter: EW must be at least 1");
   end
   if (MAX_VL < 2) begin : g_bad_vl
      $error("vzp_permuter: MAX_VL must be at least 2");
   end

   logic                 busy_q, done_q;
   logic [2:0]           op_q;
   logic [LW-1:0]        vl_q, len_q;
   logic                 mask_en_q;
   logic [DLEN-1:0]      mask_q;
   logic [DLEN*EW-1:0]   vs2_q, old_q, vd_q;
   logic [MAX_VL*EW-1:0] vs1_q;

   logic                 accept;
   logic [LW-1:0]        vl_clamp, act_len;
   logic [DLEN*EW-1:0]   cand, merged;

   assign in_ready_o = !busy_q;
   assign accept     = in_valid_i && !busy_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q    <= 1'b0;
         op_q      <= '0;
         vl_q      <= '0;
         mask_en_q <= 1'b0;
         mask_q    <= '0;
         vs2_q     <= '0;
         vs1_q     <= '0;
         old_q     <= '0;
      end else begin
         busy_q <= accept;
         if (accept) begin
            op_q      <= op_i;
            vl_q      <= vl_i;
            mask_en_q <= mask_en_i;
            mask_q    <= mask_i;
            vs2_q     <= vs2_i;
            vs1_q     <= vs1_i;
            old_q     <= vd_old_i;
         end
      end
   end

   always_comb begin
      vl_clamp = (vl_q > LW'(MAX_VL)) ? LW'(MAX_VL) : vl_q;
      case (op_q)
         OP_ZIP:                                   act_len = vl_clamp << 1;
         OP_UNZIP_E, OP_UNZIP_O, OP_PAIR_E, OP_PAIR_O: act_len = vl_clamp;
         default:                                  act_len = '0;
      endcase
   end

   vzp_src_sel #(.EW(EW), .MAX_VL(MAX_VL)) u_sel (
      .op_i   (op_q),
      .vs2_i  (vs2_q),
      .vs1_i  (vs1_q),
      .cand_o (cand)
   );

   vzp_merge #(.EW(EW), .DLEN(DLEN), .LW(LW)) u_merge (
      .cand_i    (cand),
      .old_i     (old_q),
      .mask_i    (mask_q),
      .mask_en_i (mask_en_q),
      .len_i     (act_len),
      .vd_o      (merged)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         done_q <= 1'b0;
         vd_q   <= '0;
         len_q  <= '0;
      end else begin
         done_q <= busy_q;
         if (busy_q) begin
            vd_q  <= merged;
            len_q <= act_len;
         end
      end
   end

   assign done_o = done_q;
   assign vd_o   = vd_q;
   assign len_o  = len_q;
endmodule

// File: rtl/vzp_permuter_chk.sv
module vzp_permuter_chk #(
   parameter int EW     = 8,
   parameter int MAX_VL = 8,
   localparam int DLEN  = 2 * MAX_VL,
   localparam int LW    = $clog2(DLEN + 1)
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               in_valid_i,
   input logic               in_ready_o,
   input logic               done_o,
   input logic [DLEN*EW-1:0] vd_o,
   input logic [LW-1:0]      len_o
);
   // R10
   accept_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && in_ready_o) |=> !in_ready_o);

   // R10
   busy_then_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_ready_o |=> (done_o && in_ready_o));

   // R10
   done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R11
   result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> ($stable(vd_o) && $stable(len_o)));

   // R8
   len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (len_o <= LW'(DLEN)));
endmodule

bind vzp_permuter vzp_permuter_chk #(.EW(EW), .MAX_VL(MAX_VL)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .in_valid_i (in_valid_i),
   .in_ready_o (in_ready_o),
   .done_o     (done_o),
   .vd_o       (vd_o),
   .len_o      (len_o)
);

// File: tb/tb_vzp_permuter.sv
`timescale 1ns/1ps
module tb_vzp_permuter;
   localparam int EW     = 8;
   localparam int MAX_VL = 7;
   localparam int DLEN   = 2 * MAX_VL;
   localparam int LW     = $clog2(DLEN + 1);
   localparam int DW     = DLEN * EW;
   localparam int SW     = MAX_VL * EW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic            in_valid = 1'b0;
   logic            in_ready;
   logic [2:0]      op = '0;
   logic [LW-1:0]   vl = '0;
   logic            mask_en = 1'b0;
   logic [DLEN-1:0] mask = '0;
   logic [DW-1:0]   vs2 = '0;
   logic [SW-1:0]   vs1 = '0;
   logic [DW-1:0]   vd_old = '0;
   logic            done;
   logic [DW-1:0]   vd;
   logic [LW-1:0]   len;

   vzp_permuter #(.EW(EW), .MAX_VL(MAX_VL)) dut (
      .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
      .op_i(op), .vl_i(vl), .mask_en_i(mask_en), .mask_i(mask),
      .vs2_i(vs2), .vs1_i(vs1), .vd_old_i(vd_old),
      .done_o(done), .vd_o(vd), .len_o(len)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R1 reset state";

   // reference model state
   bit              m_busy = 0, m_done = 0;
   logic [DW-1:0]   m_vd = '0;
   int              m_len = 0;
   logic [2:0]      c_op;
   int              c_vl;
   bit              c_men;
   logic [DLEN-1:0] c_mask;
   logic [DW-1:0]   c_vs2, c_old;
   logic [SW-1:0]   c_vs1;

   task automatic compute(output logic [DW-1:0] res, output int rlen);
      int vlc;
      logic [EW-1:0] e;
      vlc = (c_vl > MAX_VL) ? MAX_VL : c_vl;
      res = c_old;
      rlen = 0;
      case (c_op)
         3'd0: begin
            rlen = 2 * vlc;
            for (int i = 0; i < vlc; i++) begin
               if (!c_men || c_mask[2*i])   res[(2*i)*EW +: EW]   = c_vs2[i*EW +: EW];
               if (!c_men || c_mask[2*i+1]) res[(2*i+1)*EW +: EW] = c_vs1[i*EW +: EW];
            end
         end
         3'd1, 3'd2: begin
            rlen = vlc;
            for (int i = 0; i < vlc; i++) begin
               int s = 2*i + ((c_op == 3'd2) ? 1 : 0);
               if (!c_men || c_mask[i]) res[i*EW +: EW] = c_vs2[s*EW +: EW];
            end
         end
         3'd3, 3'd4: begin
            rlen = vlc;
            for (int k = 0; 2*k < vlc; k++) begin
               int a = 2*k + ((c_op == 3'd4) ? 1 : 0);
               e = (a < MAX_VL) ? c_vs2[a*EW +: EW] : '0;
               if (!c_men || c_mask[2*k]) res[(2*k)*EW +: EW] = e;
               if (2*k+1 < vlc && (!c_men || c_mask[2*k+1]))
                  res[(2*k+1)*EW +: EW] = c_vs1[a*EW +: EW];
            end
         end
         default: rlen = 0;
      endcase
   endtask

   task automatic chk(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      logic [DW-1:0] r;
      int rl;
      chk(in_ready === !m_busy, "in_ready", DW'(in_ready), DW'(!m_busy));
      chk(done === m_done, "done", DW'(done), DW'(m_done));
      chk(vd === m_vd, "vd", vd, m_vd);
      chk(len === LW'(m_len), "len", DW'(len), DW'(m_len));
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_vd = '0; m_len = 0;
      end else begin
         m_done = m_busy;
         if (m_busy) begin
            compute(r, rl);
            m_vd = r;
            m_len = rl;
         end
         if (in_valid && !m_busy) begin
            m_busy = 1;
            c_op = op; c_vl = int'(vl); c_men = mask_en; c_mask = mask;
            c_vs2 = vs2; c_vs1 = vs1; c_old = vd_old;
         end else begin
            m_busy = 0;
         end
      end
   end

   task automatic load(input int seed);
      for (int i = 0; i < DLEN; i++) begin
         vs2[i*EW +: EW]    = EW'(8'h10 + i * 3 + seed * 17);
         vd_old[i*EW +: EW] = EW'(8'hC0 ^ (i + seed * 5));
      end
      for (int i = 0; i < MAX_VL; i++) vs1[i*EW +: EW] = EW'(8'h80 + i * 7 + seed * 11);
   endtask

   task automatic issue(input string req, input logic [2:0] o, input int v,
                        input bit men, input logic [DLEN-1:0] m, input int seed);
      @(posedge clk); #1;
      cur_req = req;
      load(seed);
      op = o; vl = LW'(v); mask_en = men; mask = m; in_valid = 1'b1;
      @(posedge clk); #1;
      in_valid = 1'b0;
      repeat (2) @(posedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (2) @(posedge clk);
      issue("R2 zip full",           3'd0, 7, 0, '0, 1);
      issue("R2 R7 zip short",       3'd0, 3, 0, '0, 2);
      issue("R3 unzip even",         3'd1, 7, 0, '0, 3);
      issue("R3 R7 unzip odd",       3'd2, 5, 0, '0, 4);
      issue("R4 pair even odd vl",   3'd3, 5, 0, '0, 5);
      issue("R4 pair even full",     3'd3, 7, 0, '0, 6);
      issue("R5 pair odd zero force", 3'd4, 7, 0, '0, 7);
      issue("R5 pair odd vl 6",      3'd4, 6, 0, '0, 8);
      issue("R6 zip masked",         3'd0, 7, 1, 14'h2A5B, 9);
      issue("R6 pair odd masked",    3'd4, 7, 1, 14'h0055, 10);
      issue("R6 unzip mask off",     3'd2, 4, 0, 14'h0000, 11);
      issue("R8 zip vl clamp",       3'd0, 12, 0, '0, 12);
      issue("R8 unzip vl clamp",     3'd1, 15, 0, '0, 13);
      issue("R9 reserved op",        3'd6, 5, 0, '0, 14);
      issue("R7 vl zero",            3'd3, 0, 0, '0, 15);
      // R10 R11: hold valid through the busy cycle with changed data
      @(posedge clk); #1;
      cur_req = "R10 R11 busy ignore";
      load(16); op = 3'd0; vl = LW'(4); mask_en = 0; in_valid = 1'b1;
      @(posedge clk); #1;
      load(17); op = 3'd2; vl = LW'(2);
      @(posedge clk); #1;
      in_valid = 1'b0;
      repeat (4) @(posedge clk);
      #1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule